// File: doc/BRIEF.md
# Masked multi-CPU device interrupt router

This block gathers up to 64 level-sensitive device interrupt lines into one shared raw request word. It hands that word to four CPUs. Each CPU owns a 64-bit enable mask. Each CPU has one interrupt output, which is high while at least one of its enabled requests is pending. A per-CPU request view, equal to the mask ANDed with the raw word, can be read on the register bus. The view is computed on each read and is not stored. A cascaded legacy interrupt controller output is folded onto one fixed line of the raw word.

Software reaches the masks, the views and the raw word through a simple register bus. Every access must be a full 8-byte access. Each request gets exactly one registered response on the next cycle. A response carries read data or a bus error flag. Device lines and the legacy input are treated as asynchronous and pass through two flops before they reach the raw word.

Top module: `irq_router`

## Requirements
- R1: After synchronous reset every mask reads zero, every CPU interrupt output is low and no response is pending.
- R2: Each raw bit follows the level of its device line with no latching. A line change made before clock edge k shows in the raw word after edge k+1, and a line that falls clears its bit.
- R3: The legacy input is ORed into raw bit 55, which also takes device line 55.
- R4: The CPU0 to CPU3 masks are read and written at offsets 0x200, 0x240, 0x600 and 0x640. A full write replaces all 64 bits.
- R5: Reading offset 0x280, 0x2C0, 0x680 or 0x6C0 returns the mask of CPU0, CPU1, CPU2 or CPU3 ANDed with the raw word. Offset 0x300 returns the raw word.
- R6: A CPU interrupt output is high one cycle after its mask AND raw word becomes nonzero, and low one cycle after it becomes zero. Both mask writes and line changes trigger this.
- R7: Writes to the view offsets and the raw offset get an error-free response and change no state.
- R8: An access whose byte enables (bus_be, one bit per byte) are not all set gets an error response and writes nothing.
- R9: An access to any offset outside the nine decoded ones gets an error response with zero read data.
- R10: Each request gets exactly one response (bus_rsp high for one cycle) in the cycle after it is presented. Write responses and error responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | NLINES | Asynchronous level device interrupt lines |
| legacy_irq | input | 1 | Asynchronous cascaded legacy controller output |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_be | input | 8 | Byte enables, all must be set |
| bus_wdata | input | 64 | Write data |
| bus_rsp | output | 1 | Response valid |
| bus_err | output | 1 | Response is a bus error |
| bus_rdata | output | 64 | Read data |
| cpu_irq | output | NCPU | Per-CPU interrupt request |

## Verification
A mask write and a synchronised line change can land on the same clock edge. The interrupt output must then reflect both new values at once, with no glitch from the old mask or the old raw word. The bench raises a line and times a mask write so that the raw word and the mask update on the same edge. It does the same with a falling line and a clearing write. It then judges the CPU output one cycle later against the AND of the two new values. The scoreboard compares every bus response against expectations computed from a bench model of masks and lines.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned BE_W   = WORD_W / 8;
  localparam logic [15:0] RAW_OFS = 16'h0300;

  // CPU pairs sit in two groups 0x400 apart, 0x40 between CPUs of a pair
  function automatic logic [15:0] mask_ofs(input int c);
    return 16'h0200 + 16'(c / 2) * 16'h0400 + 16'(c % 2) * 16'h0040;
  endfunction

  function automatic logic [15:0] view_ofs(input int c);
    return mask_ofs(c) + 16'h0080;
  endfunction
endpackage

// File: rtl/irq_line_sync.sv
`timescale 1ns/1ps
module irq_line_sync #(
  parameter int unsigned W = 65
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/irq_cpu_port.sv
`timescale 1ns/1ps
module irq_cpu_port #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] raw,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] view,
  output logic         irq_q
);
  assign view = mask_q & raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en) mask_q <= wdata;
      irq_q <= |view;
    end
  end

  // R4: a write lands in the mask on the next edge
  a_r4_mask_load: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mask_q == $past(wdata));

  // R6: an all-zero mask can never produce an interrupt next cycle
  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_q);

  // R6: a rising interrupt needs some enabled bit one cycle before
  a_r6_rise_needs_mask: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(mask_q) != '0);
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NLINES     = 64,
  parameter int unsigned NCPU       = 4,
  parameter int unsigned LEGACY_BIT = 55,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] dev_irq,
  input  logic              legacy_irq,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_be,
  input  logic [63:0]       bus_wdata,
  output logic              bus_rsp,
  output logic              bus_err,
  output logic [63:0]       bus_rdata,
  output logic [NCPU-1:0]   cpu_irq
);
  localparam int unsigned SYNC_W = NLINES + 1;

  logic [SYNC_W-1:0]            sync_q;
  logic [WORD_W-1:0]            raw_word;
  logic [NCPU-1:0][WORD_W-1:0]  masks;
  logic [NCPU-1:0][WORD_W-1:0]  views;
  logic [NCPU-1:0]              mask_wr;
  logic                         full_be;
  logic                         hit;
  logic                         acc_ok;
  logic [WORD_W-1:0]            rd_mux;

  irq_line_sync #(.W(SYNC_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({legacy_irq, dev_irq}),
    .q   (sync_q)
  );

  always_comb begin
    raw_word = '0;
    raw_word[NLINES-1:0] = sync_q[NLINES-1:0];
    raw_word[LEGACY_BIT] = sync_q[LEGACY_BIT] | sync_q[NLINES];
  end

  assign full_be = &bus_be;

  always_comb begin
    hit    = 1'b0;
    rd_mux = '0;
    if (bus_addr == ADDR_W'(RAW_OFS)) begin
      hit    = 1'b1;
      rd_mux = raw_word;
    end
    for (int c = 0; c < NCPU; c++) begin
      if (bus_addr == ADDR_W'(mask_ofs(c))) begin
        hit    = 1'b1;
        rd_mux = masks[c];
      end
      if (bus_addr == ADDR_W'(view_ofs(c))) begin
        hit    = 1'b1;
        rd_mux = views[c];
      end
    end
    acc_ok = hit & full_be;
  end

  generate
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      assign mask_wr[c] = bus_req & bus_we & full_be &
                          (bus_addr == ADDR_W'(mask_ofs(c)));
      irq_cpu_port #(.W(WORD_W)) u_port (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (mask_wr[c]),
        .wdata  (bus_wdata),
        .raw    (raw_word),
        .mask_q (masks[c]),
        .view   (views[c]),
        .irq_q  (cpu_irq[c])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rsp   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_rsp   <= bus_req;
      bus_err   <= bus_req & ~acc_ok;
      bus_rdata <= (bus_req & acc_ok & ~bus_we) ? rd_mux : '0;
    end
  end

  // R10: a response only ever follows a request
  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    bus_rsp |-> $past(bus_req));

  // R9: error responses carry no data
  a_r9_err_no_data: assert property (@(posedge clk) disable iff (rst)
    (bus_rsp && bus_err) |-> bus_rdata == '0);

  // R8: partial byte enables leave every mask untouched
  a_r8_partial_no_write: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !full_be) |=> $stable(masks));

  // R7: writes outside the mask offsets leave the masks untouched
  a_r7_ro_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && mask_wr == '0) |=> $stable(masks));
endmodule

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] dev_irq = '0;
  logic        legacy_irq = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_be = '0;
  logic [63:0] bus_wdata = '0;
  logic        bus_rsp;
  logic        bus_err;
  logic [63:0] bus_rdata;
  logic [3:0]  cpu_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [64:0] q_exp[$];
  string       q_tag[$];
  logic [63:0] m_mask [4];

  always #2.5 clk = ~clk;

  irq_router dut (
    .clk(clk), .rst(rst), .dev_irq(dev_irq), .legacy_irq(legacy_irq),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rsp(bus_rsp), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  function automatic logic [11:0] ofs_mask(input int c);
    case (c)
      0: return 12'h200;
      1: return 12'h240;
      2: return 12'h600;
      default: return 12'h640;
    endcase
  endfunction

  function automatic logic [11:0] ofs_view(input int c);
    case (c)
      0: return 12'h280;
      1: return 12'h2C0;
      2: return 12'h680;
      default: return 12'h6C0;
    endcase
  endfunction

  function automatic logic [63:0] model_raw();
    logic [63:0] r;
    r = dev_irq;
    r[55] = r[55] | legacy_irq;
    return r;
  endfunction

  function automatic logic [3:0] model_irq();
    logic [3:0] v;
    for (int c = 0; c < 4; c++) v[c] = |(m_mask[c] & model_raw());
    return v;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (!rst && bus_rsp) begin
      n_chk++;
      if (q_exp.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected response actual=%b expected=0", bus_rsp);
      end else begin
        logic [64:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if ({bus_err, bus_rdata} !== e) begin
          n_bad++;
          $display("FAIL %s actual=%b/%h expected=%b/%h", t, bus_err, bus_rdata, e[64], e[63:0]);
        end
      end
    end
  end

  // driver: call at a falling edge; returns one falling edge after the response
  task automatic xfer(input logic we, input logic [11:0] a, input logic [7:0] be,
                      input logic [63:0] wd, input logic [63:0] exp_d,
                      input logic exp_e, input string tag);
    q_exp.push_back({exp_e, exp_d});
    q_tag.push_back(tag);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    chk({63'd0, bus_rsp}, 64'd1, "R10 response present");
    @(negedge clk);
    chk({63'd0, bus_rsp}, 64'd0, "R10 single response");
  endtask

  task automatic wr_mask(input int c, input logic [63:0] v);
    xfer(1'b1, ofs_mask(c), 8'hFF, v, 64'd0, 1'b0, "R4 mask write");
    m_mask[c] = v;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    xfer(1'b0, 12'h300, 8'hFF, '0, model_raw(), 1'b0, {tag, " R5 raw"});
    for (int c = 0; c < 4; c++) begin
      xfer(1'b0, ofs_view(c), 8'hFF, '0, m_mask[c] & model_raw(), 1'b0, {tag, " R5 view"});
      xfer(1'b0, ofs_mask(c), 8'hFF, '0, m_mask[c], 1'b0, {tag, " R4 mask"});
    end
    chk({60'd0, cpu_irq}, {60'd0, model_irq()}, {tag, " R6 cpu_irq"});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) m_mask[c] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({60'd0, cpu_irq}, 64'd0, "R1 irq after reset");
    chk({63'd0, bus_rsp}, 64'd0, "R1 no response after reset");
    check_all("R1");

    // R4 distinct mask patterns per CPU
    wr_mask(0, 64'h0000_0000_0000_00F0);
    wr_mask(1, 64'h8000_0000_0000_0001);
    wr_mask(2, 64'h0080_0000_0000_0000);
    wr_mask(3, 64'hFFFF_0000_FFFF_0000);
    check_all("R4");

    // R2 latency: raw and irq timing after a line rises
    dev_irq = 64'h0000_0000_0000_0010;
    @(negedge clk);
    @(negedge clk);
    chk({63'd0, cpu_irq[0]}, 64'd0, "R2 irq not yet");
    @(negedge clk);
    chk({63'd0, cpu_irq[0]}, 64'd1, "R2 R6 irq after two sync stages");
    check_all("R2");

    dev_irq = 64'h8001_0000_0001_0000;
    settle();
    check_all("R5 pattern");

    // R2 no latching: lines fall, bits clear
    dev_irq = '0;
    settle();
    check_all("R2 clear");

    // R3 legacy onto bit 55
    legacy_irq = 1'b1;
    settle();
    chk({63'd0, cpu_irq[2]}, 64'd1, "R3 legacy reaches CPU2");
    check_all("R3 legacy");
    dev_irq[55] = 1'b1; legacy_irq = 1'b0;
    settle();
    check_all("R3 line55");
    dev_irq = '0;
    settle();
    check_all("R3 released");

    // R7 writes to read-only offsets
    dev_irq = 64'h0000_0000_0000_00FF;
    settle();
    xfer(1'b1, 12'h300, 8'hFF, 64'hDEAD_BEEF_0000_0000, 64'd0, 1'b0, "R7 raw write");
    xfer(1'b1, 12'h2C0, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, "R7 view write");
    xfer(1'b1, 12'h680, 8'hFF, 64'h0, 64'd0, 1'b0, "R7 view write");
    check_all("R7");

    // R8 partial byte enables
    xfer(1'b1, ofs_mask(1), 8'h0F, 64'h1234, 64'd0, 1'b1, "R8 partial write");
    xfer(1'b0, ofs_mask(3), 8'h80, '0, 64'd0, 1'b1, "R8 partial read");
    check_all("R8");

    // R9 undecoded offsets
    xfer(1'b0, 12'h208, 8'hFF, '0, 64'd0, 1'b1, "R9 misaligned read");
    xfer(1'b0, 12'h100, 8'hFF, '0, 64'd0, 1'b1, "R9 other read");
    xfer(1'b1, 12'h340, 8'hFF, 64'hFFFF, 64'd0, 1'b1, "R9 write");
    check_all("R9");

    // R6 mask write and line change on the same edge
    wr_mask(0, '0);
    dev_irq = '0;
    settle();
    chk({63'd0, cpu_irq[0]}, 64'd0, "R6 idle before collision");
    dev_irq[40] = 1'b1;
    @(negedge clk);
    xfer(1'b1, ofs_mask(0), 8'hFF, 64'h0000_0100_0000_0000, 64'd0, 1'b0, "R6 collide write");
    m_mask[0] = 64'h0000_0100_0000_0000;
    chk({63'd0, cpu_irq[0]}, 64'd1, "R6 same-edge rise");
    dev_irq[40] = 1'b0;
    @(negedge clk);
    xfer(1'b1, ofs_mask(0), 8'hFF, 64'h0000_0000_0000_0002, 64'd0, 1'b0, "R6 collide write");
    m_mask[0] = 64'h0000_0000_0000_0002;
    chk({63'd0, cpu_irq[0]}, 64'd0, "R6 same-edge fall");
    check_all("R6");

    n_chk++;
    if (q_exp.size() != 0) begin
      n_bad++;
      $display("FAIL R10 missing responses actual=%0d expected=0", q_exp.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule